// File: doc/BRIEF.md
# Generalised Reverse LUT Unit

This unit passes a 64-bit operand through a chain of butterfly stages. Stage s pairs each bit with the bit whose index differs only in bit s, so the stride is 2^s. An enabled stage does not simply swap the two bits of a pair. It replaces every bit with the output of a two-input lookup table that reads both members of the pair. The member with the lower index of the pair and the member with the higher index each have their own 4-entry table, and both tables come from one 8-bit code. One code can therefore express a plain reverse, an OR-combine, a mask or a pattern generator.

The starting value is either the source operand or, when the source is marked absent, a fixed alternating pattern. An invert flag can complement that starting value. In the normal mode the low bits of the amount operand choose which stages run, and all stages share the immediate code. In row mode every stage runs and takes its own code byte from the amount operand. A narrow mode limits the network to 32-bit lanes. A request is accepted on a valid pulse, and its result is registered one clock later.

Top module: `grl_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `result` is 0.
- R2: A request presented with `in_valid` high appears on `result` with `out_valid` high at the next rising edge. A cycle with `in_valid` low clears `out_valid` and leaves `result` unchanged.
- R3: The starting value is `src`, or 0x5555_5555_5555_5555 when `src_zero` is 1. When `invert` is 1 the starting value is complemented, so an absent source with invert gives 0xAAAA_AAAA_AAAA_AAAA.
- R4: In normal mode, stage s (stride 2^s) runs only when bit s of `amount` is 1. Only `amount[5:0]` is used in 64-bit mode and only `amount[4:0]` in narrow mode. Every other bit of `amount` has no effect.
- R5: In a running stage, bit j takes the value nibble[{x[lo], x[hi]}]. Here lo = j with bit s cleared, hi = j with bit s set, and the 4-bit nibble is indexed from its LSB. The nibble is code[3:0] when bit s of j is 0 and code[7:4] otherwise.
- R6: Stages run in ascending stride order, from stride 1 up to the largest stride.
- R7: Code 0xCA with any amount gives the generalised bit reverse of the starting value. Code 0xEE gives the generalised OR-combine.
- R8: With an absent source and code 0x6C (no invert), amounts 0x2, 0x6 and 0xE give 0x1111_1111_1111_1111, 0x0101_0101_0101_0101 and 0x0001_0001_0001_0001. With code 0xC6 and invert set, the same amounts give 0x8888_8888_8888_8888, 0x8080_8080_8080_8080 and 0x8000_8000_8000_8000.
- R9: When `per_row` is 1, every stage runs, and stage s takes its code from `amount[8s+7:8s]`. A row code of 0xAC leaves that row's data unchanged, and a row code of 0xCA swaps the bits of each pair.
- R10: When `narrow` is 1, only stages 0 to 4 can run (in row mode too), and `result[63:32]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src | input | 64 | Source operand |
| src_zero | input | 1 | Source absent: start from the alternating constant |
| amount | input | 64 | Stage-enable bits, or per-stage code bytes in row mode |
| imm | input | 8 | Shared code: two 4-entry tables |
| invert | input | 1 | Complement the starting value |
| narrow | input | 1 | 32-bit mode |
| per_row | input | 1 | Take one code per stage from `amount` |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered network output |

## Verification
The reverse code 0xCA and the OR-combine code 0xEE are run on random operands and compared with a shift-and-mask reverse and combine. These runs show that the two tables are assigned to the correct members of each pair. The absent-source pattern constants, with and without invert, pin down the seed and the LUT index order. Random codes with several enabled stages catch a wrong stage order, because the lookups do not commute. In row mode, the identity and swap bytes, amounts with stray high bits, and narrow requests separate the stage-enable, masking and upper-half clearing paths.

// File: rtl/grl_pkg.sv
package grl_pkg;

    localparam int CODE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic {
        TBL_SHARED = 1'b0,
        TBL_ROW    = 1'b1
    } grl_tbl_src_e;

    typedef struct packed {
        logic         src_zero;
        logic         invert;
        logic         narrow;
        grl_tbl_src_e tbl_src;
    } grl_mode_t;

    // two-input table: index is {low member of the pair, high member}
    function automatic logic lut2_eval(input logic [NIB_W-1:0] nib,
                                       input logic lo_bit,
                                       input logic hi_bit);
        logic [1:0] idx;
        idx = {lo_bit, hi_bit};
        return nib[idx];
    endfunction

    // pick the table half for a given bit position within a stage
    function automatic logic [NIB_W-1:0] nib_pick(input logic [CODE_W-1:0] code,
                                                  input logic upper);
        return upper ? code[CODE_W-1:NIB_W] : code[NIB_W-1:0];
    endfunction

endpackage

// File: rtl/grl_seed.sv
module grl_seed
    import grl_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] src,
    input  grl_mode_t    mode,
    output logic [W-1:0] seed
);
    localparam int          PAIRS   = W / 2;
    localparam logic [W-1:0] ALT_PAT = {PAIRS{2'b01}};

    logic [W-1:0] base;

    always_comb begin
        base = mode.src_zero ? ALT_PAT : src;
        seed = mode.invert ? ~base : base;
    end
endmodule

// File: rtl/grl_ctrl.sv
module grl_ctrl
    import grl_pkg::*;
#(
    parameter int W    = 64,
    parameter int NSTG = 6
) (
    input  logic [W-1:0]             amount,
    input  logic [CODE_W-1:0]        imm,
    input  grl_mode_t                mode,
    output logic [NSTG-1:0]          stage_en,
    output logic [NSTG*CODE_W-1:0]   stage_code
);
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam bit LANE_OK = (s < NSTG - 1);
        localparam bit ROW_FIT = ((s + 1) * CODE_W <= W);

        logic active;
        logic row_mode;

        always_comb begin
            active   = LANE_OK ? 1'b1 : ~mode.narrow;
            row_mode = (mode.tbl_src == TBL_ROW);
            stage_en[s] = active & (row_mode | amount[s]);
        end

        if (ROW_FIT) begin : g_row
            always_comb begin
                stage_code[s*CODE_W +: CODE_W] =
                    row_mode ? amount[s*CODE_W +: CODE_W] : imm;
            end
        end else begin : g_norow
            always_comb begin
                stage_code[s*CODE_W +: CODE_W] = imm;
            end
        end
    end
endmodule

// File: rtl/grl_stage.sv
module grl_stage
    import grl_pkg::*;
#(
    parameter int W      = 64,
    parameter int STRIDE = 1
) (
    input  logic [W-1:0]      din,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic [W-1:0]      dout
);
    logic [NIB_W-1:0] nib_lo;
    logic [NIB_W-1:0] nib_hi;

    always_comb begin
        nib_lo = nib_pick(code, 1'b0);
        nib_hi = nib_pick(code, 1'b1);
    end

    for (genvar j = 0; j < W; j++) begin : g_bit
        localparam int  LO    = j & ~STRIDE;
        localparam int  HI    = j | STRIDE;
        localparam bit  UPPER = ((j & STRIDE) != 0);

        logic lut_out;

        always_comb begin
            lut_out = lut2_eval(UPPER ? nib_hi : nib_lo, din[LO], din[HI]);
            dout[j] = en ? lut_out : din[j];
        end
    end
endmodule

// File: rtl/grl_unit.sv
module grl_unit
    import grl_pkg::*;
#(
    parameter int W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [W-1:0]      src,
    input  logic              src_zero,
    input  logic [W-1:0]      amount,
    input  logic [CODE_W-1:0] imm,
    input  logic              invert,
    input  logic              narrow,
    input  logic              per_row,
    output logic              out_valid,
    output logic [W-1:0]      result
);
    localparam int NSTG = $clog2(W);
    localparam int HALF = W / 2;

    grl_mode_t              mode;
    logic [W-1:0]           seed;
    logic [NSTG-1:0]        stage_en;
    logic [NSTG*CODE_W-1:0] stage_code;
    logic [W-1:0]           chain [NSTG+1];
    logic [W-1:0]           net_out;

    always_comb begin
        mode.src_zero = src_zero;
        mode.invert   = invert;
        mode.narrow   = narrow;
        mode.tbl_src  = per_row ? TBL_ROW : TBL_SHARED;
    end

    grl_seed #(.W(W)) u_seed (
        .src  (src),
        .mode (mode),
        .seed (seed)
    );

    grl_ctrl #(.W(W), .NSTG(NSTG)) u_ctrl (
        .amount     (amount),
        .imm        (imm),
        .mode       (mode),
        .stage_en   (stage_en),
        .stage_code (stage_code)
    );

    always_comb chain[0] = seed;

    for (genvar s = 0; s < NSTG; s++) begin : g_net
        grl_stage #(.W(W), .STRIDE(1 << s)) u_stage (
            .din  (chain[s]),
            .en   (stage_en[s]),
            .code (stage_code[s*CODE_W +: CODE_W]),
            .dout (chain[s+1])
        );
    end

    always_comb begin
        net_out = chain[NSTG];
        if (narrow) net_out[W-1:HALF] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= net_out;
        end
    end
endmodule

// File: rtl/grl_unit_chk.sv
module grl_unit_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] src,
    input logic         src_zero,
    input logic [W-1:0] amount,
    input logic [7:0]   imm,
    input logic         invert,
    input logic         narrow,
    input logic         per_row,
    input logic         out_valid,
    input logic [W-1:0] result
);
    localparam int          NSTG    = $clog2(W);
    localparam int          HALF    = W / 2;
    localparam logic [W-1:0] ALT_PAT = {HALF{2'b01}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid not propagated"); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result))) else $error("idle changed result"); // R2

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && narrow) |=> (result[W-1:HALF] == '0)) else $error("upper half not cleared"); // R10

    AST_NO_STAGE_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !per_row && !narrow && !src_zero && !invert && amount[NSTG-1:0] == '0)
        |=> (result == $past(src))) else $error("no-stage request altered data"); // R4

    AST_CONST_SEED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_zero && !per_row && !narrow && amount[NSTG-1:0] == '0)
        |=> (result == ($past(invert) ? ~ALT_PAT : ALT_PAT))) else $error("seed constant wrong"); // R3

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && result == '0)) else $error("reset state wrong"); // R1
endmodule

bind grl_unit grl_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src       (src),
    .src_zero  (src_zero),
    .amount    (amount),
    .imm       (imm),
    .invert    (invert),
    .narrow    (narrow),
    .per_row   (per_row),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_grl_unit.sv
`timescale 1ns/1ps
module tb_grl_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] src;
    logic        src_zero;
    logic [63:0] amount;
    logic [7:0]  imm;
    logic        invert;
    logic        narrow;
    logic        per_row;
    logic        out_valid;
    logic [63:0] result;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2 clk = ~clk;

    grl_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .src_zero(src_zero),
        .amount(amount), .imm(imm), .invert(invert), .narrow(narrow),
        .per_row(per_row), .out_valid(out_valid), .result(result)
    );

    // behavioural model straight from the requirements
    function automatic logic [63:0] model(input logic [63:0] s_in, input logic zs,
            input logic [63:0] amt, input logic [7:0] code, input logic inv,
            input logic nar, input logic prow);
        logic [63:0] x, y;
        logic [7:0]  tbl;
        logic [3:0]  nib;
        int nst;
        x = zs ? 64'h5555_5555_5555_5555 : s_in;
        if (inv) x = ~x;
        nst = nar ? 5 : 6;
        for (int s = 0; s < nst; s++) begin
            int st;
            st = 1 << s;
            if (prow || amt[s]) begin
                tbl = prow ? amt[8*s +: 8] : code;
                for (int j = 0; j < 64; j++) begin
                    int lo, hi, k;
                    lo = (j < (j ^ st)) ? j : (j ^ st);
                    hi = lo + st;
                    k = 2 * int'(x[lo]) + int'(x[hi]);
                    nib = ((j & st) != 0) ? tbl[7:4] : tbl[3:0];
                    y[j] = nib[k];
                end
                x = y;
            end
        end
        if (nar) x[63:32] = 32'h0;
        return x;
    endfunction

    function automatic logic [63:0] lowmask(input int s);
        case (s)
            0: return 64'h5555_5555_5555_5555;
            1: return 64'h3333_3333_3333_3333;
            2: return 64'h0F0F_0F0F_0F0F_0F0F;
            3: return 64'h00FF_00FF_00FF_00FF;
            4: return 64'h0000_FFFF_0000_FFFF;
            default: return 64'h0000_0000_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [63:0] grev_ref(input logic [63:0] v, input logic [5:0] sh, input bit orc);
        logic [63:0] x, t;
        x = v;
        for (int s = 0; s < 6; s++) begin
            if (sh[s]) begin
                t = ((x & lowmask(s)) << (1 << s)) | ((x & ~lowmask(s)) >> (1 << s));
                x = orc ? (x | t) : t;
            end
        end
        return x;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic send(input string req, input logic [63:0] s_in, input logic zs,
            input logic [63:0] amt, input logic [7:0] code, input logic inv,
            input logic nar, input logic prow, input logic [63:0] exp);
        in_valid = 1'b1; src = s_in; src_zero = zs; amount = amt; imm = code;
        invert = inv; narrow = nar; per_row = prow;
        @(negedge clk);
        check(req, {63'h0, out_valid}, 64'h1);
        check(req, result, exp);
    endtask

    task automatic send_m(input string req, input logic [63:0] s_in, input logic zs,
            input logic [63:0] amt, input logic [7:0] code, input logic inv,
            input logic nar, input logic prow);
        send(req, s_in, zs, amt, code, inv, nar, prow,
             model(s_in, zs, amt, code, inv, nar, prow));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [63:0] r, a, held;
        rst = 1'b1; in_valid = 1'b0; src = '0; src_zero = 0; amount = '0;
        imm = '0; invert = 0; narrow = 0; per_row = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {63'h0, out_valid}, 64'h0);
        check("R1", result, 64'h0);
        rst = 1'b0;

        // R8 pattern constants
        send("R8", 64'h0, 1, 64'h2, 8'h6C, 0, 0, 0, 64'h1111_1111_1111_1111);
        send("R8", 64'h0, 1, 64'h6, 8'h6C, 0, 0, 0, 64'h0101_0101_0101_0101);
        send("R8", 64'h0, 1, 64'hE, 8'h6C, 0, 0, 0, 64'h0001_0001_0001_0001);
        send("R8", 64'h0, 1, 64'h2, 8'hC6, 1, 0, 0, 64'h8888_8888_8888_8888);
        send("R8", 64'h0, 1, 64'h6, 8'hC6, 1, 0, 0, 64'h8080_8080_8080_8080);
        send("R8", 64'h0, 1, 64'hE, 8'hC6, 1, 0, 0, 64'h8000_8000_8000_8000);

        // R3 seed selection and invert
        send("R3", 64'hDEAD_BEEF_0123_4567, 1, 64'h0, 8'h00, 0, 0, 0, 64'h5555_5555_5555_5555);
        send("R3", 64'hDEAD_BEEF_0123_4567, 1, 64'h0, 8'h00, 1, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA);
        send("R3", 64'hDEAD_BEEF_0123_4567, 0, 64'h0, 8'h00, 0, 0, 0, 64'hDEAD_BEEF_0123_4567);
        send("R3", 64'hDEAD_BEEF_0123_4567, 0, 64'h0, 8'h00, 1, 0, 0, 64'h2152_4110_FEDC_BA98);

        // R7 reverse and OR-combine against shift-and-mask references
        for (int i = 0; i < 40; i++) begin
            r = {$urandom, $urandom};
            a = {58'h0, 6'($urandom)};
            send("R7", r, 0, a, 8'hCA, 0, 0, 0, grev_ref(r, a[5:0], 0));
            send("R7", r, 0, a, 8'hEE, 0, 0, 0, grev_ref(r, a[5:0], 1));
        end
        send("R7", 64'h0123_4567_89AB_CDEF, 0, 64'h3F, 8'hCA, 0, 0, 0, 64'hF7B3_D591_E6A2_C480);

        // R4 stray amount bits are ignored
        r = 64'hCAFE_F00D_1234_8765;
        send("R4", r, 0, 64'hFFFF_FFFF_FFFF_FFC5, 8'h5B, 0, 0, 0, model(r, 0, 64'h5, 8'h5B, 0, 0, 0));
        send("R4", r, 0, 64'h0000_0000_0000_0060, 8'h5B, 0, 1, 0, 64'h0000_0000_1234_8765);
        send("R4", r, 0, 64'h0000_0000_0000_0021, 8'h5B, 0, 1, 0, model(r, 0, 64'h1, 8'h5B, 0, 1, 0));

        // R5 / R6 arbitrary codes over several stages
        for (int i = 0; i < 60; i++)
            send_m("R5", {$urandom, $urandom}, 1'($urandom), {58'h0, 6'($urandom)},
                   8'($urandom), 1'($urandom), 0, 0);
        send_m("R6", 64'h9C3A_55E1_07F2_B68D, 0, 64'h3, 8'h1E, 0, 0, 0);
        send_m("R6", 64'h9C3A_55E1_07F2_B68D, 0, 64'h30, 8'h78, 0, 0, 0);
        send("R5", 64'h1, 0, 64'h1, 8'h0C, 0, 0, 0, 64'h1);

        // R9 row mode
        r = 64'h1357_9BDF_2468_ACE0;
        send("R9", r, 0, 64'h0000_ACAC_ACAC_ACAC, 8'h00, 0, 0, 1, r);
        send("R9", r, 0, 64'h0000_CACA_CACA_CACA, 8'h00, 0, 0, 1, grev_ref(r, 6'h3F, 0));
        send("R9", r, 0, 64'h0000_ACAC_ACAC_ACCA, 8'h00, 0, 0, 1, grev_ref(r, 6'h01, 0));
        for (int i = 0; i < 30; i++)
            send_m("R9", {$urandom, $urandom}, 1'($urandom), {$urandom, $urandom},
                   8'($urandom), 1'($urandom), 0, 1);

        // R10 narrow mode
        for (int i = 0; i < 30; i++) begin
            send_m("R10", {$urandom, $urandom}, 1'($urandom), {$urandom, $urandom},
                   8'($urandom), 1'($urandom), 1, 1'($urandom));
            check("R10", result[63:32], 64'h0);
        end

        // R2 idle cycles hold the result
        send_m("R2", 64'hFEDC_BA98_7654_3210, 0, 64'h9, 8'hB4, 0, 0, 0);
        held = result;
        in_valid = 1'b0; src = ~src; imm = 8'h11; amount = 64'h3F;
        @(negedge clk);
        check("R2", {63'h0, out_valid}, 64'h0);
        check("R2", result, held);
        @(negedge clk);
        check("R2", result, held);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule